// File: doc/BRIEF.md
# Burst Configuration Command Decoder

This block watches the host write bus of a flash-style memory device and picks out the command sequence that programs its burst configuration. The sequence has three writes. The first two are fixed unlock writes. The third carries a fixed command byte on the data bus, and the new configuration code sits in the upper address bits. When the block sees the full sequence, it latches the code. From that code it gives the read path three things: the read mode (asynchronous or synchronous), the number of initial-access wait states, and the raw code bits for the other burst fields.

The read path may use synchronous burst reads only while `sync_en` is high. After reset the register holds an asynchronous default. While the program, erase or lock engine is busy, the block refuses any change to the register.

Top module: `burst_cfg_decoder`

## Requirements
- R1: After a synchronous active-low reset, `cfg_raw` is 8'h80, `sync_en` is 0 and `wait_states` is 0. Bit 7 of `cfg_raw` is the mode bit, and 1 in that bit means asynchronous.
- R2: The code loads only after three writes in this order: data AAh to low address 555h, then data 55h to low address 2AAh, then data C0h to low address 555h. "Low address" means address bits 11..0. On the third write, address bits 19..12 are captured into `cfg_raw` bits 7..0.
- R3: `sync_en` is 1 exactly when `cfg_raw[7]` (address bit 19 of the load) is 0, and 0 when that bit is 1.
- R4: `wait_states` equals `cfg_raw[2:0]`, which is address bits 14..12 of the load write.
- R5: A first or second write whose address or data does not match sends the sequencer back to idle. A C0h write to low address 555h that follows such an abort loads nothing.
- R6: If `busy` is high during the third write, the register keeps its value and the sequencer still returns to idle.
- R7: Cycles with `wr_en` low change neither the sequencer nor the register, so the three writes may have idle cycles between them.
- R8: A third write whose data is not C0h, or whose low address is not 555h, ends the sequence with no load.
- R9: The new code appears on the outputs in the cycle after the clock edge that samples the third write. Before that edge the outputs hold the old value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Host write strobe, one write per cycle while high |
| wr_addr | input | 20 | Host write address |
| wr_data | input | 8 | Host write data |
| busy | input | 1 | Program, erase or lock engine is active |
| cfg_raw | output | 8 | Latched configuration code (address bits 19..12 of the load) |
| wait_states | output | 3 | Initial-access wait-state code |
| sync_en | output | 1 | Synchronous burst reads permitted |

## Verification
Two events can fall in the same cycle: the completing third write and a `busy` flag from the program, erase and lock engine. The bench raises `busy` only for the clock of the final C0h write. It then checks at the ports that the code has not changed. It also sends a lone C0h write afterwards to prove that the sequencer went back to idle and did not stay armed. A companion case sends the same write with `busy` low and confirms that the load takes effect on the very next cycle.

// File: rtl/burst_cfg_pkg.sv
// Package: shared constants and the sequencer state type for the burst
// configuration command decoder. Assumes an 8-bit command data bus and
// a 12-bit command address field.
package burst_cfg_pkg;
    localparam int CMD_ADDR_W = 12;
    localparam int CMD_DATA_W = 8;

    localparam logic [CMD_ADDR_W-1:0] UNLOCK_A_ADDR = 12'h555;
    localparam logic [CMD_ADDR_W-1:0] UNLOCK_B_ADDR = 12'h2AA;
    localparam logic [CMD_ADDR_W-1:0] LOAD_ADDR     = 12'h555;

    localparam logic [CMD_DATA_W-1:0] UNLOCK_A_DATA = 8'hAA;
    localparam logic [CMD_DATA_W-1:0] UNLOCK_B_DATA = 8'h55;
    localparam logic [CMD_DATA_W-1:0] LOAD_DATA     = 8'hC0;

    typedef enum logic [1:0] {
        SEQ_IDLE = 2'd0,
        SEQ_GOT1 = 2'd1,
        SEQ_GOT2 = 2'd2
    } seq_state_t;
endpackage

// File: rtl/bcd_cmd_seq.sv
// Module: bcd_cmd_seq
// Tracks the two unlock writes and recognises the load write. It issues a
// one-cycle load pulse when the third write matches and the engine is not
// busy. Any write that does not match returns it to idle, and so does the
// third write itself. Assumes at most one write per clock cycle.
module bcd_cmd_seq
    import burst_cfg_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  wr_en,
    input  logic [CMD_ADDR_W-1:0] cmd_addr,
    input  logic [CMD_DATA_W-1:0] cmd_data,
    input  logic                  busy,
    output seq_state_t            state,
    output logic                  load
);
    seq_state_t state_q, state_d;
    logic hit_a, hit_b, hit_load;

    // Compare the current write against each expected step.
    always_comb begin
        hit_a    = (cmd_addr == UNLOCK_A_ADDR) && (cmd_data == UNLOCK_A_DATA);
        hit_b    = (cmd_addr == UNLOCK_B_ADDR) && (cmd_data == UNLOCK_B_DATA);
        hit_load = (cmd_addr == LOAD_ADDR)     && (cmd_data == LOAD_DATA);
    end

    // Next-state and load-pulse logic; idle cycles leave the state alone.
    always_comb begin
        state_d = state_q;
        load    = 1'b0;
        if (wr_en) begin
            unique case (state_q)
                SEQ_IDLE: state_d = hit_a ? SEQ_GOT1 : SEQ_IDLE;
                SEQ_GOT1: state_d = hit_b ? SEQ_GOT2 : SEQ_IDLE;
                SEQ_GOT2: begin
                    state_d = SEQ_IDLE;
                    load    = hit_load && !busy;
                end
                default:  state_d = SEQ_IDLE;
            endcase
        end
    end

    // State register with synchronous active-low reset.
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= SEQ_IDLE;
        else        state_q <= state_d;
    end

    assign state = state_q;
endmodule

// File: rtl/bcd_cfg_reg.sv
// Module: bcd_cfg_reg
// Holds the configuration code. It takes a new value on the load pulse
// and returns to DEFAULT_CODE on reset. Assumes the load pulse is already
// qualified by the sequencer.
module bcd_cfg_reg #(
    parameter int                 CODE_W       = 8,
    parameter logic [CODE_W-1:0]  DEFAULT_CODE = '0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [CODE_W-1:0] code_in,
    output logic [CODE_W-1:0] code_q
);
    // Code storage with synchronous reset to the default.
    always_ff @(posedge clk) begin
        if (!rst_n)    code_q <= DEFAULT_CODE;
        else if (load) code_q <= code_in;
    end
endmodule

// File: rtl/bcd_field_split.sv
// Module: bcd_field_split
// Splits the stored code into the read-mode enable and the wait-state
// field. MODE_POS gives the position of the mode bit inside the code. When
// ASYNC_HIGH is 1, a 1 in that bit means asynchronous.
module bcd_field_split #(
    parameter int CODE_W     = 8,
    parameter int WAIT_W     = 3,
    parameter int MODE_POS   = 7,
    parameter bit ASYNC_HIGH = 1'b1
) (
    input  logic [CODE_W-1:0] code,
    output logic [WAIT_W-1:0] wait_states,
    output logic              sync_en
);
    assign wait_states = code[WAIT_W-1:0];

    generate
        if (ASYNC_HIGH) begin : g_async_high
            assign sync_en = ~code[MODE_POS];
        end else begin : g_sync_high
            assign sync_en = code[MODE_POS];
        end
    endgenerate
endmodule

// File: rtl/burst_cfg_decoder.sv
// Module: burst_cfg_decoder (top)
// Decodes the three-write burst configuration command from the host write
// bus. It latches the code carried in the upper address bits of the last
// write and presents the derived read-mode fields. Assumes that `busy`
// comes from the program, erase and lock engine and is synchronous to clk.
module burst_cfg_decoder
    import burst_cfg_pkg::*;
#(
    parameter int ADDR_W   = 20,
    parameter int CODE_LSB = 12,
    parameter int WAIT_W   = 3
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         wr_en,
    input  logic [ADDR_W-1:0]            wr_addr,
    input  logic [CMD_DATA_W-1:0]        wr_data,
    input  logic                         busy,
    output logic [ADDR_W-CODE_LSB-1:0]   cfg_raw,
    output logic [WAIT_W-1:0]            wait_states,
    output logic                         sync_en
);
    localparam int                CODE_W       = ADDR_W - CODE_LSB;
    localparam int                MODE_POS     = CODE_W - 1;
    localparam logic [CODE_W-1:0] DEFAULT_CODE = CODE_W'(1) << MODE_POS;

    seq_state_t seq_state;
    logic       cfg_load;

    bcd_cmd_seq u_seq (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (wr_en),
        .cmd_addr (wr_addr[CMD_ADDR_W-1:0]),
        .cmd_data (wr_data),
        .busy     (busy),
        .state    (seq_state),
        .load     (cfg_load)
    );

    bcd_cfg_reg #(
        .CODE_W       (CODE_W),
        .DEFAULT_CODE (DEFAULT_CODE)
    ) u_reg (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (cfg_load),
        .code_in (wr_addr[ADDR_W-1:CODE_LSB]),
        .code_q  (cfg_raw)
    );

    bcd_field_split #(
        .CODE_W     (CODE_W),
        .WAIT_W     (WAIT_W),
        .MODE_POS   (MODE_POS),
        .ASYNC_HIGH (1'b1)
    ) u_split (
        .code        (cfg_raw),
        .wait_states (wait_states),
        .sync_en     (sync_en)
    );
endmodule

// File: rtl/burst_cfg_checker.sv
// Module: burst_cfg_checker
// Temporal properties of the burst configuration decoder, attached to the
// top module through bind. Assumes the top's default parameters for widths.
module burst_cfg_checker
    import burst_cfg_pkg::*;
#(
    parameter int ADDR_W   = 20,
    parameter int CODE_LSB = 12
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       wr_en,
    input  logic [ADDR_W-1:0]          wr_addr,
    input  logic [CMD_DATA_W-1:0]      wr_data,
    input  logic                       busy,
    input  seq_state_t                 seq_state,
    input  logic                       cfg_load,
    input  logic [ADDR_W-CODE_LSB-1:0] cfg_raw,
    input  logic                       sync_en
);
    localparam int CODE_W = ADDR_W - CODE_LSB;

    // R1: first cycle after reset release shows the asynchronous default
    a_r1_reset_default: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (cfg_raw == (CODE_W'(1) << (CODE_W - 1)) && !sync_en));

    // R2: a load captures the upper address bits of the load write
    a_r2_load_capture: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_load |=> (cfg_raw == $past(wr_addr[ADDR_W-1:CODE_LSB])));

    // R3: mode after a load follows address bit 19 of that write
    a_r3_mode_from_addr: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_load |=> (sync_en == !$past(wr_addr[ADDR_W-1])));

    // R5: mismatched second write drops back to idle
    a_r5_mismatch_to_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && seq_state == SEQ_GOT1 && wr_data != UNLOCK_B_DATA)
        |=> (seq_state == SEQ_IDLE));

    // R6: busy blocks any register change
    a_r6_busy_holds: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> $stable(cfg_raw));

    // R6: the sequencer is not left armed after a third write
    a_r6_third_write_idles: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && seq_state == SEQ_GOT2) |=> (seq_state == SEQ_IDLE));

    // R7: idle cycles change neither register nor sequencer
    a_r7_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> ($stable(cfg_raw) && $stable(seq_state)));
endmodule

bind burst_cfg_decoder burst_cfg_checker #(
    .ADDR_W   (ADDR_W),
    .CODE_LSB (CODE_LSB)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en     (wr_en),
    .wr_addr   (wr_addr),
    .wr_data   (wr_data),
    .busy      (busy),
    .seq_state (seq_state),
    .cfg_load  (cfg_load),
    .cfg_raw   (cfg_raw),
    .sync_en   (sync_en)
);

// File: tb/test_burst_cfg_decoder.sv
// Bench: scoreboard for burst_cfg_decoder. Driver tasks issue writes and
// push the expected code. A monitor pops each expected item and compares
// all three outputs.
module test_burst_cfg_decoder;
    localparam int CLK_PERIOD = 10;

    typedef struct {
        logic [7:0] code;
        string      tag;
    } exp_t;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [19:0] wr_addr = '0;
    logic [7:0]  wr_data = '0;
    logic        busy = 1'b0;
    logic [7:0]  cfg_raw;
    logic [2:0]  wait_states;
    logic        sync_en;

    int   n_checks = 0;
    int   n_fail = 0;
    exp_t sb_q[$];

    always #(CLK_PERIOD/2) clk = ~clk;

    burst_cfg_decoder i_burst_cfg_decoder (
        .clk         (clk),
        .rst_n       (rst_n),
        .wr_en       (wr_en),
        .wr_addr     (wr_addr),
        .wr_data     (wr_data),
        .busy        (busy),
        .cfg_raw     (cfg_raw),
        .wait_states (wait_states),
        .sync_en     (sync_en)
    );

    task automatic check(input bit ok, input string tag, input string what,
                         input logic [7:0] act, input logic [7:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
        end
    endtask

    // Monitor: compare outputs with the oldest expectation, after the edge.
    always @(posedge clk) begin
        #1;
        if (sb_q.size() > 0) begin
            exp_t e;
            e = sb_q.pop_front();
            check(cfg_raw == e.code, e.tag, "cfg_raw", cfg_raw, e.code);
            check(wait_states == e.code[2:0], e.tag, "wait_states",
                  {5'd0, wait_states}, {5'd0, e.code[2:0]});
            check(sync_en == !e.code[7], e.tag, "sync_en",
                  {7'd0, sync_en}, {7'd0, !e.code[7]});
        end
    end

    task automatic write(input logic [19:0] a, input logic [7:0] d, input bit bsy);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d; busy = bsy;
        @(negedge clk);
        wr_en = 1'b0; busy = 1'b0;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic expect_code(input logic [7:0] code, input string tag);
        sb_q.push_back('{code: code, tag: tag});
        @(negedge clk);
        while (sb_q.size() > 0) @(negedge clk);
    endtask

    task automatic full_seq(input logic [7:0] code, input bit bsy);
        write(20'h00555, 8'hAA, 1'b0);
        write(20'h002AA, 8'h55, 1'b0);
        write({code, 12'h555}, 8'hC0, bsy);
    endtask

    initial begin
        #(CLK_PERIOD * 20000);
        n_fail++;
        n_checks++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        idle(3);
        @(negedge clk) rst_n = 1'b1;
        // R1: reset default is asynchronous, code 80h
        expect_code(8'h80, "R1");

        // R2 R3 R4 R9: synchronous load, code 35h; check timing by hand
        write(20'h00555, 8'hAA, 1'b0);
        write(20'h002AA, 8'h55, 1'b0);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = {8'h35, 12'h555}; wr_data = 8'hC0;
        #1 check(cfg_raw == 8'h80, "R9", "before edge", cfg_raw, 8'h80);
        @(posedge clk); #1;
        check(cfg_raw == 8'h35, "R9", "after edge", cfg_raw, 8'h35);
        @(negedge clk) wr_en = 1'b0;
        expect_code(8'h35, "R2");

        // R3 R4: asynchronous load with wait code 2
        full_seq(8'hA2, 1'b0);
        expect_code(8'hA2, "R3");

        // R5: wrong second unlock data, then C0h alone
        write(20'h00555, 8'hAA, 1'b0);
        write(20'h002AA, 8'h56, 1'b0);
        write({8'h11, 12'h555}, 8'hC0, 1'b0);
        expect_code(8'hA2, "R5");
        // R5: wrong first unlock address
        write(20'h00554, 8'hAA, 1'b0);
        write(20'h002AA, 8'h55, 1'b0);
        write({8'h12, 12'h555}, 8'hC0, 1'b0);
        expect_code(8'hA2, "R5");

        // R7: idle gaps between the writes still load
        write(20'h00555, 8'hAA, 1'b0);
        idle(3);
        write(20'h002AA, 8'h55, 1'b0);
        idle(2);
        write({8'h07, 12'h555}, 8'hC0, 1'b0);
        expect_code(8'h07, "R7");

        // R6: busy during the third write blocks the load
        full_seq(8'h44, 1'b1);
        expect_code(8'h07, "R6");
        // R6: the sequencer is idle, so a lone load write does nothing
        write({8'h99, 12'h555}, 8'hC0, 1'b0);
        expect_code(8'h07, "R6");
        // R6: same sequence with busy low loads
        full_seq(8'h44, 1'b0);
        expect_code(8'h44, "R6");

        // R8: wrong third data aborts, then a lone C0h does nothing
        write(20'h00555, 8'hAA, 1'b0);
        write(20'h002AA, 8'h55, 1'b0);
        write({8'h23, 12'h555}, 8'hF0, 1'b0);
        write({8'h24, 12'h555}, 8'hC0, 1'b0);
        expect_code(8'h44, "R8");
        // R8: wrong third low address
        write(20'h00555, 8'hAA, 1'b0);
        write(20'h002AA, 8'h55, 1'b0);
        write({8'h25, 12'h556}, 8'hC0, 1'b0);
        expect_code(8'h44, "R8");

        // R1: reset restores the default after a load
        @(negedge clk) rst_n = 1'b0;
        idle(2);
        @(negedge clk) rst_n = 1'b1;
        expect_code(8'h80, "R1");

        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule